// File: doc/BRIEF.md
# Subroutine and Stack Frame Sequencer

This block carries out the stack side of six control-transfer operations for a processor core: call a subroutine, return, return with condition-flag restore, return from an exception, build a frame and tear a frame down. It holds the stack pointer itself. It receives, already decoded, the operation, the 3-bit register field, the current program counter, the call target and a 16-bit frame displacement. It then steps through the stack traffic needed, one 16-bit bus word at a time. A 32-bit value always takes two accesses: the upper half goes to the lower address.

When the operation ends, the block raises a one-cycle completion strobe. At the same time it presents the new program counter, the restored status word or condition flags, and a write to the selected address register where the operation changes it. It also reports the fixed cycle cost of the operation. While it is idle, the stack pointer can be loaded from outside. The register file lives outside the block: the current value of the selected address register is supplied with the command. When the register field selects 7, the stack pointer stands in for that register, and the steps run in their normal order on it.

Top module: `stack_frame_seq`

## Requirements
- R1: Call (cmd_op=0) lowers the stack pointer by 4 and writes the return address to the new top. The return address is cmd_pc, or cmd_pc+2 when cmd_ext is 1. The upper half goes to address SP and the lower half to SP+2. The call raises pc_we with pc_out=cmd_target and reports a cost of 18.
- R2: Return (cmd_op=1) reads a 32-bit value from SP (upper half) and SP+2 (lower half) and loads it into pc_out. It raises the stack pointer by 4 and reports a cost of 16.
- R3: Flag-restoring return (cmd_op=2) first reads one word at SP and then reads a 32-bit program counter at SP+2 and SP+4. Only bits 4:0 of the word (carry bit 0, overflow bit 1, zero bit 2, negative bit 3, extend bit 4) appear on ccr_out, with ccr_we raised and sr_we low. The stack pointer rises by 6 and the cost is 20.
- R4: Exception return (cmd_op=3) pops the same frame shape as R3, but loads the full 16-bit word onto sr_out with sr_we raised and ccr_we low. The stack pointer rises by 6 and the cost is 20.
- R5: Frame build (cmd_op=4) lowers SP by 4 and writes the selected register's value (areg_rdata) to the new top. It writes that new SP to the register (areg_we), then adds the sign-extended cmd_disp to SP. The cost is 16.
- R6: Frame teardown (cmd_op=5) copies the selected register into SP and reads a 32-bit value there. The value goes into the register (areg_we), SP rises by 4, and the cost is 12.
- R7: With cmd_reg=7, the R5 and R6 steps act on the stack pointer itself and areg_we stays low. Frame build stores the decremented SP and ends at that value plus the displacement. Frame teardown ends at the loaded value plus 4.
- R8: Each bus access holds mem_req, mem_we, mem_addr and mem_wdata steady until mem_ack is sampled high. No further access starts before that.
- R9: done is a single-cycle pulse that comes with cycles. pc_we, sr_we, ccr_we and areg_we are raised only in a done cycle.
- R10: After reset, busy, done, mem_req and all strobes are 0, and sp_out, pc_out, sr_out, ccr_out, areg_wdata and cycles are 0.
- R11: cmd_op values 6 and 7 start nothing. cmd_valid is ignored while busy. sp_wr_en loads sp_wr_data into the stack pointer only while idle with no command being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start an operation (accepted only while idle) |
| cmd_op | input | 3 | Operation code 0..5, see R1-R6 |
| cmd_reg | input | 3 | Address register field (opcode bits 2:0) |
| cmd_ext | input | 1 | Call uses the extension-word form (return address +2) |
| cmd_pc | input | 32 | Program counter after the opcode word |
| cmd_target | input | 32 | Call destination |
| cmd_disp | input | 16 | Signed frame displacement |
| areg_rdata | input | 32 | Current value of the selected address register |
| sp_wr_en | input | 1 | Load the stack pointer while idle |
| sp_wr_data | input | 32 | Stack pointer load value |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| cycles | output | 5 | Cost of the completed operation |
| pc_we | output | 1 | pc_out is a new program counter |
| pc_out | output | 32 | New program counter |
| sr_we | output | 1 | sr_out is a full status word |
| sr_out | output | 16 | Restored status word |
| ccr_we | output | 1 | ccr_out holds restored flags |
| ccr_out | output | 5 | Restored flags X,N,Z,V,C (bit 4..0) |
| areg_we | output | 1 | Write areg_wdata to the selected register |
| areg_wdata | output | 32 | New selected-register value |
| sp_out | output | 32 | Current stack pointer |

## Verification
The assertions assume that mem_ack is raised only while mem_req is high. They also assume that cmd_pc, cmd_target, cmd_disp and areg_rdata are valid in the cycle a command is accepted. The bench responder acknowledges only open requests and inserts 0 to 2 wait cycles in a rotating pattern. All command fields are driven for exactly the accepting cycle. Commands are issued only while idle, except for one deliberate command and stack pointer load sent during a return to show that they are dropped.

// File: rtl/stkseq_pkg.sv
// Shared types for the stack frame sequencer.
// Assumes a 3-bit operation code; values 6 and 7 are not operations.
package stkseq_pkg;

    typedef enum logic [2:0] {
        OP_CALL   = 3'd0,
        OP_RET    = 3'd1,
        OP_RETFLG = 3'd2,
        OP_RETEXC = 3'd3,
        OP_FRMBLD = 3'd4,
        OP_FRMTDN = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_SR,
        ST_RD_HI,
        ST_RD_LO,
        ST_FINISH
    } st_e;

    localparam logic [2:0] SP_INDEX = 3'd7;
    localparam int unsigned FLAG_W  = 5;

endpackage

// File: rtl/stkseq_cost.sv
// Cycle-cost lookup: maps an operation to its fixed cost.
// Assumes CYC_W is wide enough to hold the largest cost (20).
module stkseq_cost
    import stkseq_pkg::*;
#(
    parameter int unsigned CYC_W = 5
) (
    input  op_e              op,
    output logic [CYC_W-1:0] cost
);

    // Fixed cost per operation, independent of bus wait states.
    always_comb begin
        unique case (op)
            OP_CALL:   cost = CYC_W'(18);
            OP_RET:    cost = CYC_W'(16);
            OP_RETFLG: cost = CYC_W'(20);
            OP_RETEXC: cost = CYC_W'(20);
            OP_FRMBLD: cost = CYC_W'(16);
            OP_FRMTDN: cost = CYC_W'(12);
            default:   cost = '0;
        endcase
    end

endmodule

// File: rtl/stkseq_busif.sv
// Bus request decode: turns the sequencer state into one word access.
// Assumes the second word of a 32-bit transfer sits WORD_W/8 bytes above
// the first, with the upper half at the lower address.
module stkseq_busif
    import stkseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WORD_W = 16
) (
    input  st_e               st,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] wbuf,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

    // Request, direction, address and data for the current state.
    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = sp;
        wdata = wbuf[WORD_W-1:0];
        unique case (st)
            ST_WR_HI: begin
                req   = 1'b1;
                we    = 1'b1;
                wdata = wbuf[ADDR_W-1:ADDR_W-WORD_W];
            end
            ST_WR_LO: begin
                req  = 1'b1;
                we   = 1'b1;
                addr = sp + WORD_BYTES;
            end
            ST_RD_SR, ST_RD_HI: req = 1'b1;
            ST_RD_LO: begin
                req  = 1'b1;
                addr = sp + WORD_BYTES;
            end
            default: req = 1'b0;
        endcase
    end

endmodule

// File: rtl/stack_frame_seq.sv
// Stack frame sequencer: runs call, return, flag-restoring return,
// exception return, frame build and frame teardown as word accesses.
// Assumes mem_ack only while mem_req, and command fields valid in the
// accepting cycle. The selected register lives outside, except index 7,
// which is the stack pointer held here.
module stack_frame_seq
    import stkseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CYC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [2:0]        cmd_reg,
    input  logic              cmd_ext,
    input  logic [ADDR_W-1:0] cmd_pc,
    input  logic [ADDR_W-1:0] cmd_target,
    input  logic [WORD_W-1:0] cmd_disp,
    input  logic [ADDR_W-1:0] areg_rdata,
    input  logic              sp_wr_en,
    input  logic [ADDR_W-1:0] sp_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [CYC_W-1:0]  cycles,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_out,
    output logic              sr_we,
    output logic [WORD_W-1:0] sr_out,
    output logic              ccr_we,
    output logic [FLAG_W-1:0] ccr_out,
    output logic              areg_we,
    output logic [ADDR_W-1:0] areg_wdata,
    output logic [ADDR_W-1:0] sp_out
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);
    localparam logic [ADDR_W-1:0] LONG_BYTES = ADDR_W'(2 * (WORD_W / 8));
    localparam logic [2:0]        LAST_OP    = 3'(OP_FRMTDN);

    st_e               st_q;
    op_e               op_q;
    logic [2:0]        reg_q;
    logic [ADDR_W-1:0] ret_q, tgt_q, areg_q, sp_q, wbuf_q, rbuf_q;
    logic [WORD_W-1:0] disp_q, word_q;
    logic [CYC_W-1:0]  cost;
    logic              accept;
    logic              reg_is_sp;
    logic [ADDR_W-1:0] disp_ext;

    assign accept    = (st_q == ST_IDLE) && cmd_valid && (cmd_op <= LAST_OP);
    assign reg_is_sp = (reg_q == SP_INDEX);
    assign disp_ext  = {{(ADDR_W-WORD_W){disp_q[WORD_W-1]}}, disp_q};
    assign busy      = (st_q != ST_IDLE);
    assign sp_out    = sp_q;

    stkseq_cost #(.CYC_W(CYC_W)) cost_i (
        .op   (op_q),
        .cost (cost)
    );

    stkseq_busif #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) bus_i (
        .st    (st_q),
        .sp    (sp_q),
        .wbuf  (wbuf_q),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    // Sequencer state, stack pointer, operand latches and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            op_q       <= OP_CALL;
            reg_q      <= '0;
            ret_q      <= '0;
            tgt_q      <= '0;
            areg_q     <= '0;
            disp_q     <= '0;
            sp_q       <= '0;
            wbuf_q     <= '0;
            rbuf_q     <= '0;
            word_q     <= '0;
            done       <= 1'b0;
            cycles     <= '0;
            pc_we      <= 1'b0;
            pc_out     <= '0;
            sr_we      <= 1'b0;
            sr_out     <= '0;
            ccr_we     <= 1'b0;
            ccr_out    <= '0;
            areg_we    <= 1'b0;
            areg_wdata <= '0;
        end else begin
            done    <= 1'b0;
            pc_we   <= 1'b0;
            sr_we   <= 1'b0;
            ccr_we  <= 1'b0;
            areg_we <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q   <= op_e'(cmd_op);
                        reg_q  <= cmd_reg;
                        ret_q  <= cmd_ext ? cmd_pc + WORD_BYTES : cmd_pc;
                        tgt_q  <= cmd_target;
                        disp_q <= cmd_disp;
                        areg_q <= areg_rdata;
                        st_q   <= ST_SETUP;
                    end else if (sp_wr_en) begin
                        sp_q <= sp_wr_data;
                    end
                end
                ST_SETUP: begin
                    unique case (op_q)
                        OP_CALL: begin
                            sp_q   <= sp_q - LONG_BYTES;
                            wbuf_q <= ret_q;
                            st_q   <= ST_WR_HI;
                        end
                        OP_FRMBLD: begin
                            sp_q   <= sp_q - LONG_BYTES;
                            wbuf_q <= reg_is_sp ? sp_q - LONG_BYTES : areg_q;
                            st_q   <= ST_WR_HI;
                        end
                        OP_RET:               st_q <= ST_RD_HI;
                        OP_RETFLG, OP_RETEXC: st_q <= ST_RD_SR;
                        OP_FRMTDN: begin
                            if (!reg_is_sp) sp_q <= areg_q;
                            st_q <= ST_RD_HI;
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
                ST_WR_HI: if (mem_ack) st_q <= ST_WR_LO;
                ST_WR_LO: if (mem_ack) st_q <= ST_FINISH;
                ST_RD_SR: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        sp_q   <= sp_q + WORD_BYTES;
                        st_q   <= ST_RD_HI;
                    end
                end
                ST_RD_HI: begin
                    if (mem_ack) begin
                        rbuf_q[ADDR_W-1:ADDR_W-WORD_W] <= mem_rdata;
                        st_q <= ST_RD_LO;
                    end
                end
                ST_RD_LO: begin
                    if (mem_ack) begin
                        rbuf_q[WORD_W-1:0] <= mem_rdata;
                        st_q <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    done   <= 1'b1;
                    cycles <= cost;
                    st_q   <= ST_IDLE;
                    unique case (op_q)
                        OP_CALL: begin
                            pc_we  <= 1'b1;
                            pc_out <= tgt_q;
                        end
                        OP_RET: begin
                            pc_we  <= 1'b1;
                            pc_out <= rbuf_q;
                            sp_q   <= sp_q + LONG_BYTES;
                        end
                        OP_RETFLG: begin
                            pc_we   <= 1'b1;
                            pc_out  <= rbuf_q;
                            ccr_we  <= 1'b1;
                            ccr_out <= word_q[FLAG_W-1:0];
                            sp_q    <= sp_q + LONG_BYTES;
                        end
                        OP_RETEXC: begin
                            pc_we  <= 1'b1;
                            pc_out <= rbuf_q;
                            sr_we  <= 1'b1;
                            sr_out <= word_q;
                            sp_q   <= sp_q + LONG_BYTES;
                        end
                        OP_FRMBLD: begin
                            if (!reg_is_sp) begin
                                areg_we    <= 1'b1;
                                areg_wdata <= sp_q;
                            end
                            sp_q <= sp_q + disp_ext;
                        end
                        OP_FRMTDN: begin
                            if (reg_is_sp) begin
                                sp_q <= rbuf_q + LONG_BYTES;
                            end else begin
                                areg_we    <= 1'b1;
                                areg_wdata <= rbuf_q;
                                sp_q       <= sp_q + LONG_BYTES;
                            end
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R8: an open request stays unchanged until it is acknowledged.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R9: completion lasts exactly one cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: result strobes only accompany completion.
    p_strobe_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || sr_we || ccr_we || areg_we) |-> done);

    // R3/R4: full status and flag restore never together.
    p_sr_ccr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_we, ccr_we}));

    // R11: an idle sequencer makes no bus access.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: idle with no load and no command leaves the stack pointer alone.
    p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid && !sp_wr_en) |=> $stable(sp_out));

endmodule

// File: tb/stack_frame_seq_tb.sv
// Bench: behavioural model with an expected-access queue, checked against
// every bus access, every clock's strobes, and each completion.
module stack_frame_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_reg = '0;
    logic        cmd_ext = 1'b0;
    logic [31:0] cmd_pc = '0;
    logic [31:0] cmd_target = '0;
    logic [15:0] cmd_disp = '0;
    logic [31:0] areg_rdata = '0;
    logic        sp_wr_en = 1'b0;
    logic [31:0] sp_wr_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        busy, done, pc_we, sr_we, ccr_we, areg_we;
    logic [4:0]  cycles, ccr_out;
    logic [31:0] pc_out, areg_wdata, sp_out;
    logic [15:0] sr_out;

    always #4 clk = ~clk;

    stack_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_ext(cmd_ext), .cmd_pc(cmd_pc),
        .cmd_target(cmd_target), .cmd_disp(cmd_disp), .areg_rdata(areg_rdata),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
        .cycles(cycles), .pc_we(pc_we), .pc_out(pc_out), .sr_we(sr_we),
        .sr_out(sr_out), .ccr_we(ccr_we), .ccr_out(ccr_out),
        .areg_we(areg_we), .areg_wdata(areg_wdata), .sp_out(sp_out)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] sp_m = '0;
    logic [15:0] mem [logic [31:0]];
    logic [31:0] q_addr [$];
    logic        q_we   [$];
    logic [15:0] q_dat  [$];
    string       q_tag  [$];
    int wcnt = 0;
    int wpat = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd16(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    task automatic push_acc(input logic [31:0] a, input logic w,
                            input logic [15:0] d, input string t);
        q_addr.push_back(a); q_we.push_back(w); q_dat.push_back(d); q_tag.push_back(t);
    endtask

    // Memory responder: 0..2 wait cycles, checks each access against the model (R8).
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ack = 1'b0;
        end else if (wcnt > 0) begin
            wcnt--;
            mem_ack = 1'b0;
        end else begin
            mem_ack = 1'b1;
            wpat = (wpat + 1) % 3;
            wcnt = wpat;
            if (q_addr.size() == 0) begin
                chk("R8", "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
            end else begin
                chk(q_tag[0], "access addr", mem_addr, q_addr[0]);
                chk(q_tag[0], "access dir", {31'd0, mem_we}, {31'd0, q_we[0]});
                if (q_we[0]) chk(q_tag[0], "write data", {16'd0, mem_wdata}, {16'd0, q_dat[0]});
                void'(q_addr.pop_front()); void'(q_we.pop_front());
                void'(q_dat.pop_front());  void'(q_tag.pop_front());
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata = rd16(mem_addr);
        end
    end

    // Every clock: strobes only with done, no access while idle (R9, R11).
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", "strobe without done", {31'd0, (pc_we | sr_we | ccr_we | areg_we) & ~done}, 32'd0);
            chk("R11", "access while idle", {31'd0, mem_req & ~busy}, 32'd0);
        end
    end

    task automatic load_sp(input logic [31:0] v);
        @(negedge clk); sp_wr_en = 1'b1; sp_wr_data = v;
        @(negedge clk); sp_wr_en = 1'b0;
        sp_m = v;
        chk("R11", "sp load", sp_out, v);
    endtask

    // Model one operation, issue it, and compare the completion outputs.
    task automatic run_op(input logic [2:0] op, input logic [2:0] rg, input logic ext,
                          input logic [31:0] pc, input logic [31:0] tgt,
                          input logic [15:0] disp, input logic [31:0] av,
                          input bit poke, input string tag);
        logic [31:0] e_pc = 32'd0, e_ar = 32'd0, v = 32'd0;
        logic [15:0] w = 16'd0;
        logic e_pcwe = 1'b0, e_srwe = 1'b0, e_ccwe = 1'b0, e_arwe = 1'b0;
        int e_cyc = 0;
        int t = 0;
        case (op)
            3'd0: begin
                sp_m = sp_m - 4; v = ext ? pc + 2 : pc;
                push_acc(sp_m, 1'b1, v[31:16], tag); push_acc(sp_m + 2, 1'b1, v[15:0], tag);
                e_pcwe = 1'b1; e_pc = tgt; e_cyc = 18;
            end
            3'd1: begin
                push_acc(sp_m, 1'b0, 16'd0, tag); push_acc(sp_m + 2, 1'b0, 16'd0, tag);
                e_pc = {rd16(sp_m), rd16(sp_m + 2)}; sp_m = sp_m + 4;
                e_pcwe = 1'b1; e_cyc = 16;
            end
            3'd2, 3'd3: begin
                w = rd16(sp_m); push_acc(sp_m, 1'b0, 16'd0, tag); sp_m = sp_m + 2;
                push_acc(sp_m, 1'b0, 16'd0, tag); push_acc(sp_m + 2, 1'b0, 16'd0, tag);
                e_pc = {rd16(sp_m), rd16(sp_m + 2)}; sp_m = sp_m + 4;
                e_pcwe = 1'b1; e_cyc = 20;
                if (op == 3'd2) e_ccwe = 1'b1; else e_srwe = 1'b1;
            end
            3'd4: begin
                sp_m = sp_m - 4; v = (rg == 3'd7) ? sp_m : av;
                push_acc(sp_m, 1'b1, v[31:16], tag); push_acc(sp_m + 2, 1'b1, v[15:0], tag);
                if (rg != 3'd7) begin e_arwe = 1'b1; e_ar = sp_m; end
                sp_m = sp_m + {{16{disp[15]}}, disp}; e_cyc = 16;
            end
            default: begin
                if (rg != 3'd7) sp_m = av;
                push_acc(sp_m, 1'b0, 16'd0, tag); push_acc(sp_m + 2, 1'b0, 16'd0, tag);
                v = {rd16(sp_m), rd16(sp_m + 2)};
                if (rg == 3'd7) sp_m = v + 4;
                else begin e_arwe = 1'b1; e_ar = v; sp_m = sp_m + 4; end
                e_cyc = 12;
            end
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = rg; cmd_ext = ext; cmd_pc = pc;
        cmd_target = tgt; cmd_disp = disp; areg_rdata = av;
        @(negedge clk);
        cmd_valid = 1'b0; areg_rdata = 32'h5A5A_5A5A; cmd_pc = 32'h0BAD_0BAD;
        if (poke) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd0; sp_wr_en = 1'b1; sp_wr_data = 32'h7777_0000;
            chk("R11", "busy during poke", {31'd0, busy}, 32'd1);
            @(negedge clk);
            cmd_valid = 1'b0; sp_wr_en = 1'b0;
        end
        while (!done && t < 300) begin @(negedge clk); t++; end
        chk(tag, "completion seen", {31'd0, done}, 32'd1);
        chk(tag, "cycles", {27'd0, cycles}, e_cyc);
        chk(tag, "pc_we", {31'd0, pc_we}, {31'd0, e_pcwe});
        if (e_pcwe) chk(tag, "pc_out", pc_out, e_pc);
        chk(tag, "sr_we", {31'd0, sr_we}, {31'd0, e_srwe});
        if (e_srwe) chk(tag, "sr_out", {16'd0, sr_out}, {16'd0, w});
        chk(tag, "ccr_we", {31'd0, ccr_we}, {31'd0, e_ccwe});
        if (e_ccwe) chk(tag, "ccr_out", {27'd0, ccr_out}, {27'd0, w[4:0]});
        chk(tag, "areg_we", {31'd0, areg_we}, {31'd0, e_arwe});
        if (e_arwe) chk(tag, "areg_wdata", areg_wdata, e_ar);
        chk(tag, "sp_out", sp_out, sp_m);
        chk(tag, "pending accesses", q_addr.size(), 32'd0);
        @(negedge clk);
        chk("R9", "done single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R10", "sp after reset", sp_out, 32'd0);
        chk("R10", "done after reset", {31'd0, done}, 32'd0);
        chk("R10", "req after reset", {31'd0, mem_req}, 32'd0);
        chk("R10", "pc after reset", pc_out, 32'd0);
        chk("R10", "cycles after reset", {27'd0, cycles}, 32'd0);

        load_sp(32'h0000_1000);
        run_op(3'd0, 3'd0, 1'b0, 32'h0000_0200, 32'h0000_0380, 16'd0, 32'd0, 1'b0, "R1");
        run_op(3'd0, 3'd0, 1'b1, 32'h1234_5678, 32'h0000_0400, 16'd0, 32'd0, 1'b0, "R1");
        run_op(3'd1, 3'd0, 1'b0, 32'd0, 32'd0, 16'd0, 32'd0, 1'b0, "R2");
        run_op(3'd1, 3'd0, 1'b0, 32'd0, 32'd0, 16'd0, 32'd0, 1'b1, "R2");

        mem[32'h2000] = 16'hFFEA; mem[32'h2002] = 16'h0000; mem[32'h2004] = 16'h0ABC;
        mem[32'h2006] = 16'hA71F; mem[32'h2008] = 16'h8000; mem[32'h200A] = 16'h0010;
        mem[32'h2018] = 16'h0000; mem[32'h201A] = 16'h3000;
        load_sp(32'h0000_2000);
        run_op(3'd2, 3'd0, 1'b0, 32'd0, 32'd0, 16'd0, 32'd0, 1'b0, "R3");
        run_op(3'd3, 3'd0, 1'b0, 32'd0, 32'd0, 16'd0, 32'd0, 1'b0, "R4");
        run_op(3'd4, 3'd3, 1'b0, 32'd0, 32'd0, 16'hFFF8, 32'hDEAD_BEEF, 1'b0, "R5");
        run_op(3'd5, 3'd3, 1'b0, 32'd0, 32'd0, 16'd0, 32'h0000_2008, 1'b0, "R6");
        run_op(3'd4, 3'd7, 1'b0, 32'd0, 32'd0, 16'h0010, 32'h5555_5555, 1'b0, "R7");
        chk("R7", "self-stored frame word", {rd16(32'h2008), rd16(32'h200A)}, 32'h0000_2008);
        run_op(3'd5, 3'd7, 1'b0, 32'd0, 32'd0, 16'd0, 32'h5555_5555, 1'b0, "R7");

        // R11: undefined operation codes start nothing.
        for (int k = 6; k < 8; k++) begin
            @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'(k);
            @(negedge clk); cmd_valid = 1'b0;
            repeat (3) begin
                @(negedge clk);
                chk("R11", "busy after undefined op", {31'd0, busy}, 32'd0);
            end
            chk("R11", "sp after undefined op", sp_out, sp_m);
        end
        finish_run();
    end

endmodule